// File: doc/BRIEF.md
# Serial EEPROM Page Write Sequencer

This block sits behind the serial slave engine of a two-wire EEPROM and handles the write side of a transaction. When the word address is received, the block latches the page number and the starting offset. Each data byte that follows goes into a page-sized holding buffer. The offset that selects the buffer slot wraps inside the page, so bytes beyond the page size overwrite the earliest slots. The page number never moves.

A stop condition ends the transaction. If at least one byte was received and the write-protect input is low at that moment, the block starts its internal write window. Busy is raised for a fixed, parameterised number of clock cycles. During the early part of that window the block walks the page slots in ascending order and emits one array write for each slot that was filled. Slots that were not filled keep their old contents in the array.

While busy, the block ignores new bytes, new addresses and further stops, which matches a device that withholds its acknowledge during programming. The write-protect input keeps its effect for the whole window: any slot reached while it is high is not written.

Top module: `eeprom_page_writer`

## Requirements
- R1: After synchronous reset, busy and the array write enable are both low.
- R2: A data byte goes to array address {page, offset}. Page is the word address bits [12:5] latched at the address load. The offset starts at address bits [4:0] and advances by one per byte, wrapping from 31 to 0 within the same page.
- R3: When more than 32 bytes arrive, each later byte replaces the earlier one in the slot it lands on. Each slot is written once, holding the last byte it received.
- R4: Only slots that received a byte in the current transaction are written. Offset k is written in the k-th busy cycle, counting the first busy cycle as cycle 0, so the writes come out in ascending offset order.
- R5: Busy rises on the clock edge that samples a qualifying stop and stays high for exactly WRITE_CYCLES cycles.
- R6: A stop with no data bytes since the address load starts no write window: busy stays low and nothing is written.
- R7: If write protect is high when the stop is sampled, no write window starts, nothing is written, and the received bytes are discarded.
- R8: In any busy cycle where write protect is high, the array write enable stays low. Busy still runs its full length.
- R9: While busy, the byte strobe, the address load and the stop strobe have no effect on the writes, the busy length or the next transaction.
- R10: The array write enable is asserted only while busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Word-address phase complete; latch addr_in |
| addr_in | input | 13 | Word address from the slave engine |
| byte_valid | input | 1 | One complete data byte is available |
| byte_data | input | 8 | Data byte |
| stop | input | 1 | Stop condition seen on the bus |
| wp | input | 1 | Write protect, high blocks writes |
| busy | output | 1 | Internal write window active |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 13 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The checker watches, on every cycle, several relations between ports: the write enable stays inside busy and is never high with protection active; busy only rises after a stop sampled with protection low; the page bits stay fixed and the offset advances by one through the whole window; and a window never runs longer or shorter than WRITE_CYCLES. Whether the right bytes land in the right slots can only be seen in the bench's scenarios. That covers offset wrap, overflow replacement, untouched slots, dropped transactions after a dummy write or a protected stop, and inputs ignored during busy. For these, the expected write list is built from the requirements and compared against the port activity.

// File: rtl/eeprom_pw_pkg.sv
// Package: shared widths and types for the page write sequencer.
// Assumes byte-wide array data.
package eeprom_pw_pkg;
    parameter int unsigned PW_DATA_W = 8;
    typedef logic [PW_DATA_W-1:0] pw_byte_t;
endpackage

// File: rtl/pw_page_buffer.sv
// Module: holding buffer for one page. It keeps the data slots, a fill
// mask and the wrapping slot pointer. Assumes ld and wr never coincide
// with a need to keep old mask bits: ld always empties the mask.
module pw_page_buffer
    import eeprom_pw_pkg::*;
#(
    parameter int unsigned PAGE_BITS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld,
    input  logic [PAGE_BITS-1:0] ld_ptr,
    input  logic                 clr,
    input  logic                 wr,
    input  pw_byte_t             wr_data,
    input  logic [PAGE_BITS-1:0] rd_idx,
    output pw_byte_t             rd_data,
    output logic                 rd_valid,
    output logic                 any_valid
);
    localparam int unsigned SLOTS = 1 << PAGE_BITS;

    pw_byte_t             store [SLOTS];
    logic [SLOTS-1:0]     filled;
    logic [PAGE_BITS-1:0] ptr;

    // Data slots: capture the incoming byte at the current pointer.
    always_ff @(posedge clk) begin
        if (wr) begin
            store[ptr] <= wr_data;
        end
    end

    // Fill mask: emptied on a new address or a clear, marked on each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filled <= '0;
        end else if (ld || clr) begin
            filled <= '0;
        end else if (wr) begin
            filled[ptr] <= 1'b1;
        end
    end

    // Slot pointer: loaded from the low address bits, wraps in the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ld) begin
            ptr <= ld_ptr;
        end else if (wr) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Read side used by the commit scan.
    always_comb begin
        rd_data   = store[rd_idx];
        rd_valid  = filled[rd_idx];
        any_valid = |filled;
    end
endmodule

// File: rtl/pw_write_timer.sv
// Module: write-window timer. A start pulse raises busy for exactly
// CYCLES clocks. elapsed counts busy cycles from 0, and done marks the
// last one. Assumes start is only given while not busy.
module pw_write_timer #(
    parameter int unsigned CYCLES = 48,
    localparam int unsigned CW = $clog2(CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic [CW-1:0] elapsed,
    output logic          done
);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    // Last cycle of the window.
    always_comb done = busy && (elapsed == LAST);

    // Busy flag and elapsed-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            elapsed <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            elapsed <= '0;
        end else if (done) begin
            busy    <= 1'b0;
            elapsed <= '0;
        end else if (busy) begin
            elapsed <= elapsed + 1'b1;
        end
    end
endmodule

// File: rtl/eeprom_page_writer.sv
// Module: page write sequencer top. It collects data bytes into a page
// buffer, starts a timed write window on stop, and scans the buffer onto
// the array port, one slot per busy cycle. Assumes the slave engine gives
// single-cycle strobes, and that WRITE_CYCLES covers a full page scan.
module eeprom_page_writer
    import eeprom_pw_pkg::*;
#(
    parameter int unsigned ADDR_W       = 13,
    parameter int unsigned PAGE_BITS    = 5,
    parameter int unsigned WRITE_CYCLES = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              stop,
    input  logic              wp,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam int unsigned SLOTS  = 1 << PAGE_BITS;
    localparam int unsigned PAGE_W = ADDR_W - PAGE_BITS;
    localparam int unsigned CW     = $clog2(WRITE_CYCLES + 1);

    generate
        if (WRITE_CYCLES < SLOTS) begin : g_bad_cfg
            $error("WRITE_CYCLES must cover one page scan");
        end
    endgenerate

    logic [PAGE_W-1:0] page_q;
    logic [CW-1:0]     elapsed;
    logic              done;
    logic              ld, wr, start, clr;
    logic              any_valid, rd_valid;
    pw_byte_t          rd_data;

    // Strobe qualification: inputs count only outside the write window.
    always_comb begin
        ld    = addr_load && !busy;
        wr    = byte_valid && !busy && !stop && !addr_load;
        start = stop && !busy && any_valid && !wp;
        clr   = (stop && !busy && !start) || done;
    end

    // Page number latched at the word-address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (ld) begin
            page_q <= addr_in[ADDR_W-1:PAGE_BITS];
        end
    end

    pw_page_buffer #(.PAGE_BITS(PAGE_BITS)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (ld),
        .ld_ptr    (addr_in[PAGE_BITS-1:0]),
        .clr       (clr),
        .wr        (wr),
        .wr_data   (byte_data),
        .rd_idx    (elapsed[PAGE_BITS-1:0]),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    pw_write_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .elapsed (elapsed),
        .done    (done)
    );

    // Commit scan: slot index follows the elapsed busy cycles.
    always_comb begin
        mem_addr  = {page_q, elapsed[PAGE_BITS-1:0]};
        mem_wdata = rd_data;
        mem_we    = busy && (int'(elapsed) < SLOTS) && rd_valid && !wp;
    end
endmodule

// File: rtl/pw_checker.sv
// Module: property checker for the page write sequencer, bound to the
// top. It watches ports only, plus a local busy-length counter.
module pw_checker #(
    parameter int unsigned ADDR_W       = 13,
    parameter int unsigned PAGE_BITS    = 5,
    parameter int unsigned WRITE_CYCLES = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop,
    input logic              wp,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    int unsigned run_len;

    // Counts completed busy cycles of the current window.
    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else run_len <= 0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !busy && !mem_we); // R1
    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> busy); // R10
    AST_WE_NOT_WP: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> !wp); // R8
    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop) && !$past(wp)); // R5
    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(mem_addr[ADDR_W-1:PAGE_BITS])); // R2
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |->
        mem_addr[PAGE_BITS-1:0] == ($past(mem_addr[PAGE_BITS-1:0]) + 1'b1)); // R4
    AST_BUSY_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_len < WRITE_CYCLES); // R5
    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_len == WRITE_CYCLES); // R5
endmodule

bind eeprom_page_writer pw_checker #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .WRITE_CYCLES(WRITE_CYCLES)
) u_pw_chk (
    .clk(clk), .rst_n(rst_n), .stop(stop), .wp(wp),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/tb_eeprom_page_writer.sv
// Scoreboard bench: the driver predicts array writes into a queue, and a
// monitor pops and compares them as mem_we pulses.
module tb_eeprom_page_writer;
    localparam int CLK_PERIOD = 10;
    localparam int WT = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_load = 1'b0;
    logic [12:0] addr_in = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop = 1'b0;
    logic        wp = 1'b0;
    logic        busy, mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata;

    int total = 0;
    int bad = 0;
    logic [20:0] exp_q[$];

    eeprom_page_writer #(.WRITE_CYCLES(WT)) dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_valid(byte_valid), .byte_data(byte_data), .stop(stop), .wp(wp),
        .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: every array write must match the next predicted write.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            check("R10", "write outside busy", busy, 1'b1);
            if (exp_q.size() == 0) begin
                check("R4", "unexpected write", {mem_addr, mem_wdata}, 32'hFFFFFFFF);
            end else begin
                check("R4", "write addr/data", {mem_addr, mem_wdata}, exp_q.pop_front());
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // One transaction: address, n bytes, stop. The write prediction is
    // built from the requirements alone.
    task automatic txn(input logic [12:0] a, input int n, input logic [7:0] base,
                       input bit wp_stop, input int wp_rise, input bit noise);
        bit       v[32];
        logic [7:0] d[32];
        int ptr = int'(a[4:0]);
        bit go = (n > 0) && !wp_stop;
        int cnt = 0;
        for (int i = 0; i < 32; i++) v[i] = 1'b0;
        for (int i = 0; i < n; i++) begin
            d[ptr] = base + 8'(i);
            v[ptr] = 1'b1;
            ptr = (ptr + 1) % 32;
        end
        if (go) begin
            for (int k = 0; k < 32; k++)
                if (v[k] && (wp_rise < 0 || k < wp_rise))
                    exp_q.push_back({a[12:5], 5'(k), d[k]});
        end
        addr_load = 1'b1; addr_in = a;
        tick();
        addr_load = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1; byte_data = base + 8'(i);
            tick();
        end
        byte_valid = 1'b0;
        wp = wp_stop; stop = 1'b1;
        tick();
        stop = 1'b0;
        check(go ? "R5" : (wp_stop ? "R7" : "R6"), "busy after stop", busy, go);
        if (go) begin
            while (busy && cnt < WT + 5) begin
                cnt++;
                if (wp_rise >= 0 && cnt == wp_rise) wp = 1'b1;
                if (noise && cnt == 5) begin
                    byte_valid = 1'b1; byte_data = 8'hEE; addr_load = 1'b1;
                    addr_in = 13'h1FFF; stop = 1'b1;
                end else if (noise && cnt == 6) begin
                    byte_valid = 1'b0; addr_load = 1'b0; stop = 1'b0;
                end
                tick();
            end
            check(wp_rise >= 0 ? "R8" : (noise ? "R9" : "R5"), "busy length", cnt, WT);
        end else begin
            for (int i = 0; i < 3; i++) tick();
            check(wp_stop ? "R7" : "R6", "busy stays low", busy, 1'b0);
        end
        wp = 1'b0;
        tick();
        check("R4", "all predicted writes seen", exp_q.size(), 0);
    endtask

    // A lone stop: must not start a window when the buffer is empty.
    task automatic stop_only(string req);
        stop = 1'b1;
        tick();
        stop = 1'b0;
        check(req, "lone stop busy", busy, 1'b0);
        tick();
        check(req, "lone stop busy later", busy, 1'b0);
    endtask

    initial begin
        repeat (3) tick();
        check("R1", "reset busy", busy, 1'b0);
        check("R1", "reset we", mem_we, 1'b0);
        rst_n = 1'b1;
        tick();
        check("R1", "idle busy", busy, 1'b0);
        // R2 R4 R5: four bytes from offset 3
        txn(13'h0123, 4, 8'h10, 1'b0, -1, 1'b0);
        // R2: wrap from offset 30 to 1 within page
        txn(13'h1F5E, 4, 8'h20, 1'b0, -1, 1'b0);
        // R3: 35 bytes, first three slots replaced
        txn(13'h0400, 35, 8'h40, 1'b0, -1, 1'b0);
        // R6: dummy write
        txn(13'h0A00, 0, 8'h00, 1'b0, -1, 1'b0);
        // R7: protected at stop, then a lone stop shows the buffer dropped
        txn(13'h0800, 3, 8'h90, 1'b1, -1, 1'b0);
        stop_only("R7");
        // R8: protection rises in busy cycle 2
        txn(13'h0C00, 8, 8'hA0, 1'b0, 2, 1'b0);
        // R9: strobes during busy ignored
        txn(13'h0660, 6, 8'hC0, 1'b0, -1, 1'b1);
        stop_only("R9");
        // R4: sparse fill leaves other slots untouched
        txn(13'h0E11, 2, 8'h55, 1'b0, -1, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule